// File: doc/BRIEF.md
# Iterative AES Block Encryptor

This block encrypts one 128-bit block under AES. It computes one cipher round per clock cycle in a single 128-bit state register. It does not expand the key. An outside key stepper watches the `rk_idx` output and drives the matching 128-bit round key on `rk_in` in the same cycle. A two-bit select chooses 10, 12 or 14 rounds, which match 128, 192 and 256-bit keys. The select is captured when a block is accepted.

The input side is a valid/ready handshake. A block is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low for the whole computation, so no second block can enter while one is in flight. The output side has no back-pressure. `out_valid` is a one-cycle strobe. `out_block` keeps the ciphertext until the next block is accepted. `in_ready` is already high in the strobe cycle, so a new block can follow the previous one with no gap. Each block takes Nr+1 cycles: one cycle loads the whitened block and Nr cycles compute the rounds.

Top module: `aes_iter_enc`

## Requirements
- R1: While and after reset, with no block accepted yet, `in_ready` is 1, `out_valid` is 0 and `rk_idx` is 0.
- R2: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 until the result strobe. While `in_ready` is 0, `in_valid` and `in_block` have no effect: the running result does not change and no extra result appears.
- R3: `key_len` sets the round count Nr: 2'b00 gives 10, 2'b01 gives 12, and 2'b10 or 2'b11 give 14. Only the value present at the accepting edge counts.
- R4: `rk_idx` is 0 while idle, during the accepting cycle and during the strobe cycle. During the cycle after the accepting edge it is 1. It then rises by one per cycle up to Nr.
- R5: `out_valid` is high for exactly one cycle: the cycle that follows the Nr-th rising edge after the accepting edge.
- R6: In the `out_valid` cycle `in_ready` is 1. `out_block` stays unchanged from the strobe until the next block is accepted.
- R7: Byte k of a 128-bit vector (k = 0 is bits 127:120, byte k is bits 127-8k down to 120-8k) lands in state row k mod 4 and column k div 4. This applies to `in_block`, `rk_in` and `out_block`.
- R8: The result is standard AES. Key 0 is XORed in first. Rounds 1 to Nr-1 apply SubBytes, ShiftRows (row r rotated left by r bytes), MixColumns (circulant 2,3,1,1 over GF(2^8) modulo 0x11B) and then the key for that round. Round Nr leaves out MixColumns.
- R9: SubBytes sends each byte through the standard S-box. The S-box is the multiplicative inverse in GF(2^8), with 0 mapped to 0, followed by the affine map with constant 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_block | input | 128 | Plaintext, byte 0 in the top bits |
| key_len | input | 2 | Round-count select, captured at acceptance |
| rk_idx | output | 4 | Index of the round key wanted on `rk_in` this cycle |
| rk_in | input | 128 | Round key driven by the key stepper |
| out_valid | output | 1 | One-cycle strobe: ciphertext present |
| out_block | output | 128 | Ciphertext, held until next acceptance |

## Verification
The result strobe of one block and the acceptance of the next block can fall in the same cycle. In that cycle `in_ready` has just risen and `rk_idx` has returned to 0. The bench's driver offers each new block as soon as it sees `in_ready`, so every job in the run follows the previous one with no gap. The monitor then checks, in that shared cycle, that the finished ciphertext is correct, that `rk_idx` is 0 for the incoming block's key 0, and that the new block's latency is again exactly Nr edges. Known-answer vectors for all three key sizes and a run of pseudo-random blocks and keys are scored against a model in the bench that has its own key schedule.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  typedef logic [7:0] gf8_t;

  localparam int unsigned BLK_W  = 128;
  localparam int unsigned NBYTES = BLK_W / 8;
  localparam int unsigned NROWS  = 4;
  localparam int unsigned NCOLS  = NBYTES / NROWS;
  localparam int unsigned COL_W  = NROWS * 8;
  localparam gf8_t        RED_POLY = 8'h1b;
  localparam gf8_t        AFF_C    = 8'h63;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic gf8_t gf_dbl(input gf8_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
  endfunction

  function automatic gf8_t gf_mul(input gf8_t a, input gf8_t b);
    gf8_t acc;
    gf8_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  function automatic gf8_t rotl8(input gf8_t a, input int unsigned n);
    return gf8_t'((a << n) | (a >> (8 - n)));
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_iter_pkg::*;
(
  input  gf8_t din,
  output gf8_t dout
);

  localparam int unsigned SQ_STEPS = 7;

  gf8_t pw [SQ_STEPS+1];
  gf8_t inv;

  // inverse as x^254 = x^2 * x^4 * ... * x^128; 0 maps to 0
  always_comb begin
    pw[0] = din;
    for (int k = 1; k <= SQ_STEPS; k++) pw[k] = gf_mul(pw[k-1], pw[k-1]);
    inv = pw[1];
    for (int k = 2; k <= SQ_STEPS; k++) inv = gf_mul(inv, pw[k]);
  end

  assign dout = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
              ^ rotl8(inv, 4) ^ AFF_C;

endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_iter_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);

  gf8_t a [NROWS];
  gf8_t b [NROWS];

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign a[r] = col_i[COL_W-1-8*r -: 8];
    // 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
    assign b[r] = gf_dbl(a[r])
                ^ gf_dbl(a[(r+1) % NROWS]) ^ a[(r+1) % NROWS]
                ^ a[(r+2) % NROWS]
                ^ a[(r+3) % NROWS];
    assign col_o[COL_W-1-8*r -: 8] = b[r];
  end

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_iter_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  input  logic [BLK_W-1:0] rk_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] st_o
);

  gf8_t             sb [NBYTES];
  logic [BLK_W-1:0] sr_v;
  logic [BLK_W-1:0] mc_v;

  // byte k sits at row k%4, column k/4
  for (genvar k = 0; k < NBYTES; k++) begin : g_sub
    aes_sbox u_sbox (
      .din  (st_i[BLK_W-1-8*k -: 8]),
      .dout (sb[k])
    );
  end

  // row r rotated left by r columns
  for (genvar c = 0; c < NCOLS; c++) begin : g_shc
    for (genvar r = 0; r < NROWS; r++) begin : g_shr
      assign sr_v[BLK_W-1-8*(NROWS*c+r) -: 8] = sb[NROWS*((c+r) % NCOLS) + r];
    end
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_mix
    aes_mixcol u_mix (
      .col_i (sr_v[BLK_W-1-COL_W*c -: COL_W]),
      .col_o (mc_v[BLK_W-1-COL_W*c -: COL_W])
    );
  end

  assign st_o = (last_i ? sr_v : mc_v) ^ rk_i;

endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl #(
  parameter int unsigned NR_SHORT = 10,
  parameter int unsigned NR_MID   = 12,
  parameter int unsigned NR_LONG  = 14,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       key_len,
  output logic             in_ready,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [IDX_W-1:0] rk_idx,
  output logic             out_valid
);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] rnd_q;
  logic [IDX_W-1:0] nr_q;
  logic [IDX_W-1:0] nr_sel;

  always_comb begin
    case (key_len)
      2'b00:   nr_sel = IDX_W'(NR_SHORT);
      2'b01:   nr_sel = IDX_W'(NR_MID);
      default: nr_sel = IDX_W'(NR_LONG);
    endcase
  end

  assign in_ready  = !busy_q;
  assign load      = in_valid && !busy_q;
  assign step      = busy_q;
  assign last      = busy_q && (rnd_q == nr_q);
  assign rk_idx    = rnd_q;
  assign out_valid = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
      nr_q   <= '0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        rnd_q  <= IDX_W'(1);
        nr_q   <= nr_sel;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          rnd_q  <= '0;
        end else begin
          rnd_q <= rnd_q + IDX_W'(1);
        end
      end
    end
  end

  // R2
  accept_closes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_idx != '0 && rk_idx != nr_q) |=> (rk_idx == IDX_W'($past(rk_idx) + 1'b1)));

  // R3
  final_key_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(rk_idx) == nr_q));

endmodule

// File: rtl/aes_iter_enc.sv
module aes_iter_enc
  import aes_iter_pkg::*;
#(
  parameter int unsigned NR_SHORT = 10,
  parameter int unsigned NR_MID   = 12,
  parameter int unsigned NR_LONG  = 14,
  parameter int unsigned IDX_W    = $clog2(NR_LONG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  input  logic [1:0]       key_len,
  output logic [IDX_W-1:0] rk_idx,
  input  logic [BLK_W-1:0] rk_in,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block
);

  logic             load;
  logic             step;
  logic             last;
  logic [BLK_W-1:0] state_q;
  logic [BLK_W-1:0] rnd_out;

  aes_ctrl #(
    .NR_SHORT (NR_SHORT),
    .NR_MID   (NR_MID),
    .NR_LONG  (NR_LONG),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .key_len   (key_len),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .last      (last),
    .rk_idx    (rk_idx),
    .out_valid (out_valid)
  );

  aes_round u_round (
    .st_i   (state_q),
    .rk_i   (rk_in),
    .last_i (last),
    .st_o   (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= in_block ^ rk_in;
    else if (step) state_q <= rnd_out;
  end

  assign out_block = state_q;

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(in_valid && in_ready)) |=> $stable(out_block));

  // R4
  idle_key_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (rk_idx == '0));

  // R6
  ready_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

endmodule

// File: tb/aes_iter_enc_tb.sv
module aes_iter_enc_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_block;
  logic [1:0]   key_len;
  logic [3:0]   rk_idx;
  logic [127:0] rk_in;
  logic         out_valid;
  logic [127:0] out_block;

  always #5 clk = ~clk;

  aes_iter_enc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .key_len   (key_len),
    .rk_idx    (rk_idx),
    .rk_in     (rk_in),
    .out_valid (out_valid),
    .out_block (out_block)
  );

  logic [127:0] keys_cur [16];
  logic [127:0] keys_nx  [16];
  logic [7:0]   sbt      [256];
  logic [127:0] exp_q    [$];
  logic [127:0] last_ct;
  logic [31:0]  seed = 32'h2545f491;

  int  checks = 0, errors = 0, cyc = 0;
  int  acc_cyc = 0, cur_nr = 0, n_in = 0, n_out = 0;
  bit  act = 0, mon_en = 0, prev_ov = 0;

  // key stepper: presents the key the block asks for
  always_comb rk_in = keys_cur[rk_idx];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic       hi;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p = p ^ a;
      hi = a[7];
      a  = a << 1;
      if (hi) a = a ^ 8'h1b;
      b  = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] rl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  // S-box by exhaustive inverse search (R9)
  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      if (x != 0)
        for (int y = 1; y < 256; y++)
          if (mul8(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sbt[x] = inv ^ rl8(inv, 1) ^ rl8(inv, 2) ^ rl8(inv, 3) ^ rl8(inv, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
  endfunction

  task automatic expand(input logic [255:0] key, input int nk, input int nr);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = mul8(rc, 8'h02);
      end else if (nk > 6 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < 16; r++)
      keys_nx[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
  endtask

  // reference: state s[row][col], byte k at row k%4, column k/4 (R7)
  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input int nr);
    logic [7:0]   s [4][4];
    logic [7:0]   t [4][4];
    logic [7:0]   a [4];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = pt[127-8*(4*c+r) -: 8] ^ keys_nx[0][127-8*(4*c+r) -: 8];
    for (int rd = 1; rd <= nr; rd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[r][c] = sbt[s[r][c]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r][c] = t[r][(c+r)%4];
      if (rd < nr)
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++) a[r] = s[r][c];
          for (int r = 0; r < 4; r++)
            s[r][c] = mul8(a[r], 8'h02) ^ mul8(a[(r+1)%4], 8'h03) ^ a[(r+2)%4] ^ a[(r+3)%4];
        end
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r][c] = s[r][c] ^ keys_nx[rd][127-8*(4*c+r) -: 8];
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) o[127-8*(4*c+r) -: 8] = s[r][c];
    return o;
  endfunction

  // driver: offers a block as soon as in_ready is seen, pushes expected result
  task automatic send(input logic [127:0] pt, input logic [255:0] key, input logic [1:0] kl,
                      input bit poke, output logic [127:0] ct);
    int nk, nr;
    case (kl)
      2'b00:   begin nk = 4; nr = 10; end
      2'b01:   begin nk = 6; nr = 12; end
      default: begin nk = 8; nr = 14; end
    endcase
    expand(key, nk, nr);
    ct = ref_enc(pt, nr);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int r = 0; r < 16; r++) keys_cur[r] = keys_nx[r];
    in_block = pt;
    key_len  = kl;
    in_valid = 1'b1;
    exp_q.push_back(ct);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    act      = 1'b1;
    acc_cyc  = cyc;
    cur_nr   = nr;
    n_in++;
    if (poke) begin
      // R2 R3: offers and select changes while busy must not matter
      repeat (3) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_block = ~pt;
        key_len  = (kl == 2'b00) ? 2'b10 : 2'b00;
      end
      @(negedge clk);
      in_valid = 1'b0;
      key_len  = kl;
    end
  endtask

  task automatic nxt32(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        check(in_ready, "R6 in_ready in strobe cycle", 128'(in_ready), 128'd1);
        check(rk_idx == 4'd0, "R4 rk_idx in strobe cycle", 128'(rk_idx), 128'd0);
        check(!prev_ov, "R5 strobe longer than one cycle", 128'(prev_ov), 128'd0);
        if (act)
          check(cyc - acc_cyc == cur_nr, "R5 latency", 128'(cyc - acc_cyc), 128'(cur_nr));
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 result without accepted block", out_block, 128'h0);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          check(out_block == e, "R8 ciphertext", out_block, e);
        end
        last_ct = out_block;
        act     = 1'b0;
        n_out++;
      end else if (act) begin
        check(rk_idx == 4'(cyc - acc_cyc + 1), "R4 rk_idx step", 128'(rk_idx), 128'(cyc - acc_cyc + 1));
        check(!in_ready, "R2 in_ready while busy", 128'(in_ready), 128'd0);
      end else begin
        check(rk_idx == 4'd0, "R4 rk_idx idle", 128'(rk_idx), 128'd0);
        check(in_ready, "R2 in_ready idle", 128'(in_ready), 128'd1);
      end
      prev_ov = out_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] ct;
    logic [31:0]  v [12];
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_block = '0;
    key_len  = 2'b00;
    for (int r = 0; r < 16; r++) keys_cur[r] = '0;
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(in_ready == 1'b1, "R1 in_ready in reset", 128'(in_ready), 128'd1);
    check(out_valid == 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
    check(rk_idx == 4'd0, "R1 rk_idx in reset", 128'(rk_idx), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && rk_idx == 4'd0, "R1 state after reset",
          {in_ready, out_valid, rk_idx}, 128'b100000);
    mon_en = 1'b1;

    // R8 R7 R3: known answers for each key size
    send(128'h00112233445566778899aabbccddeeff, {128'h000102030405060708090a0b0c0d0e0f, 128'h0},
         2'b00, 1'b0, ct);
    check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R8 model 128-bit key", ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    send(128'h00112233445566778899aabbccddeeff,
         {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 2'b01, 1'b0, ct);
    check(ct == 128'hdda97ca4864cdfe06eaf70a0ec0d7191, "R8 model 192-bit key", ct,
          128'hdda97ca4864cdfe06eaf70a0ec0d7191);
    send(128'h00112233445566778899aabbccddeeff,
         256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 2'b10, 1'b0, ct);
    check(ct == 128'h8ea2b7ca516745bfeafc49904b496089, "R8 model 256-bit key", ct,
          128'h8ea2b7ca516745bfeafc49904b496089);
    // R3: select 2'b11 also gives 14 rounds
    send(128'h00112233445566778899aabbccddeeff,
         256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 2'b11, 1'b0, ct);
    // R2 R3: offers and select changes during busy are ignored
    send(128'h00112233445566778899aabbccddeeff, {128'h000102030405060708090a0b0c0d0e0f, 128'h0},
         2'b00, 1'b1, ct);
    send(128'hffeeddccbbaa99887766554433221100,
         {192'h0f1e2d3c4b5a69788796a5b4c3d2e1f00112233445566778, 64'h0}, 2'b01, 1'b1, ct);
    // R9 R7: all-zero and all-ones blocks and keys
    send(128'h0, 256'h0, 2'b00, 1'b0, ct);
    send({128{1'b1}}, {256{1'b1}}, 2'b10, 1'b0, ct);
    // back-to-back pseudo-random jobs, strobe and next acceptance share a cycle
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 12; i++) nxt32(v[i]);
      send({v[0], v[1], v[2], v[3]}, {v[4], v[5], v[6], v[7], v[8], v[9], v[10], v[11]},
           2'(j % 4), 1'(j % 3 == 0), ct);
    end

    while (act || exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    // R6: result held while idle
    check(out_block == last_ct, "R6 result held after strobe", out_block, last_ct);
    check(n_out == n_in, "R2 one result per accepted block", 128'(n_out), 128'(n_in));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule